// File: doc/BRIEF.md
# Triggered Multi-Buffer Transfer Sequencer

This block owns a buffer memory in which every entry carries a transmit word, a control word, a receive word and a status word. The entries are divided into consecutive transfer groups. Each group has its own trigger selection and its own trigger condition. When a group's condition is met, the sequencer walks the group's entries in ascending order. For each entry it offers the transmit and control words to an external serial word engine and waits for the engine to finish. It then stores the received word and a status word back into the same entry. No processor write is needed to start a transfer.

Group boundaries are given by one end index per group. Group 0 starts at entry 0, and every later group starts one entry past the end of the group before it. Only one group runs at a time. Trigger events that arrive while a group is running are kept pending, and pending groups are served lowest number first. A group set to low-level mode starts again each time it finishes, for as long as its source is still low. A plain buffer port lets the surrounding logic load transmit and control words, read back receive and status words, and acknowledge a received word as read.

Top module: `mseq_top`

## Requirements
- R1: After reset `xfer_req` and `grp_done` are low, and every entry reads back a zero status word.
- R2: Group g covers entries start..end. The start of group 0 is 0 and the start of group g is end(g-1)+1. Its entries are offered in ascending order. Each entry's words are shown on `xfer_tx`/`xfer_ctrl` with `xfer_req` high, and they stay there until `xfer_done` is sampled high.
- R3: When `xfer_done` is sampled high, the entry in flight stores `xfer_rx` as its receive word. Its status gets bit 0 (done) = 1 and bit 2 (unread) = 1, and bits 15..3 = 0.
- R4: Status bit 1 (overrun) takes the value that the entry's unread bit had just before the write-back. A `host_take` pulse clears bit 2 of entry `host_ridx`. A write-back in the same cycle wins.
- R5: A select value s in 1..NUM_SRC picks `trig_in[s-1]`, and the value 0 never fires. Mode bit 0 fires on a rising edge of the selected source and mode bit 1 fires while it is low. Sources pass two synchronizing flops before detection.
- R6: When several groups are pending, the lowest-numbered group is served first, and groups never overlap.
- R7: A trigger event that arrives during a run is held and served after the run ends.
- R8: A group in low-level mode restarts after each run while its source stays low, and stops once the source is high.
- R9: `grp_done[g]` pulses for one cycle, in the cycle after group g's last write-back, once per run. At most one bit is high at a time.
- R10: A group whose end is below its start never runs, and its triggers are discarded.
- R11: `host_we` with `host_wsel`=0 writes the transmit word and with `host_wsel`=1 writes the control word of entry `host_widx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_we | input | 1 | Buffer word write strobe |
| host_wsel | input | 1 | 0 = transmit word, 1 = control word |
| host_widx | input | IDX_W | Entry to write |
| host_wdata | input | DATA_W | Write data |
| host_ridx | input | IDX_W | Entry to read |
| host_take | input | 1 | Mark receive word of `host_ridx` as read |
| host_rx | output | DATA_W | Receive word of `host_ridx` |
| host_stat | output | DATA_W | Status word of `host_ridx` |
| cfg_end | input | NUM_GROUPS*IDX_W | Per-group end index, group g at bits [g*IDX_W +: IDX_W] |
| cfg_sel | input | NUM_GROUPS*SEL_W | Per-group trigger select, group g at bits [g*SEL_W +: SEL_W] |
| cfg_mode | input | NUM_GROUPS | Per-group trigger mode, 0 edge, 1 low level |
| trig_in | input | NUM_SRC | Asynchronous trigger sources |
| xfer_req | output | 1 | Word request to the engine |
| xfer_tx | output | DATA_W | Transmit word of the entry in flight |
| xfer_ctrl | output | DATA_W | Control word of the entry in flight |
| xfer_done | input | 1 | Engine finished the word |
| xfer_rx | input | DATA_W | Received word, valid with `xfer_done` |
| grp_done | output | NUM_GROUPS | Per-group completion pulse |

## Verification
The checks assume three things about the inputs. The engine raises `xfer_done` only while `xfer_req` is high. Nobody rewrites the transmit or control word of an entry while that entry is in flight. The group configuration changes only while the block is idle. The bench's engine model answers only requests it has seen, the bench loads buffer words only before the first trigger, and it reprograms selects and modes only after a quiet period with no request. Trigger pulses are held for several clocks, so the synchronizers always see them.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
   localparam int unsigned STAT_DONE_BIT  = 0;
   localparam int unsigned STAT_OVR_BIT   = 1;
   localparam int unsigned STAT_UNRD_BIT  = 2;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_t;
endpackage

// File: rtl/mseq_trig.sv
module mseq_trig #(
   parameter int unsigned NUM_GROUPS = 4,
   parameter int unsigned NUM_SRC    = 15,
   parameter int unsigned SEL_W      = 4
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [NUM_SRC-1:0]            trig_in,
   input  logic [NUM_GROUPS*SEL_W-1:0]   cfg_sel,
   input  logic [NUM_GROUPS-1:0]         cfg_mode,
   output logic [NUM_GROUPS-1:0]         evt
);
   logic [NUM_SRC-1:0] sync1, sync2, prev;

   // Two-stage synchronizer plus one history stage; idle-high reset
   always_ff @(posedge clk) begin
      if (rst) begin
         sync1 <= '1;
         sync2 <= '1;
         prev  <= '1;
      end else begin
         sync1 <= trig_in;
         sync2 <= sync1;
         prev  <= sync2;
      end
   end

   // index 0 stands for "no source"
   logic [NUM_SRC:0] now_ext, old_ext;
   assign now_ext = {sync2, 1'b1};
   assign old_ext = {prev,  1'b1};

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic [SEL_W-1:0] sel;
      logic             cur, old, used;
      assign sel  = cfg_sel[g*SEL_W +: SEL_W];
      assign used = (sel != '0);
      assign cur  = now_ext[sel];
      assign old  = old_ext[sel];
      assign evt[g] = used & (cfg_mode[g] ? ~cur : (cur & ~old));
   end
endmodule

// File: rtl/mseq_map.sv
module mseq_map #(
   parameter int unsigned NUM_GROUPS = 4,
   parameter int unsigned IDX_W      = 7
) (
   input  logic [NUM_GROUPS*IDX_W-1:0]       cfg_end,
   output logic [NUM_GROUPS-1:0][IDX_W-1:0]  g_start,
   output logic [NUM_GROUPS-1:0][IDX_W-1:0]  g_end,
   output logic [NUM_GROUPS-1:0]             g_valid
);
   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic [IDX_W:0] start_w;
      assign g_end[g] = cfg_end[g*IDX_W +: IDX_W];
      if (g == 0) begin : g_first
         assign start_w = '0;
      end else begin : g_next
         assign start_w = {1'b0, cfg_end[(g-1)*IDX_W +: IDX_W]} + {{IDX_W{1'b0}}, 1'b1};
      end
      assign g_start[g] = start_w[IDX_W-1:0];
      assign g_valid[g] = ({1'b0, g_end[g]} >= start_w);
   end
endmodule

// File: rtl/mseq_bufmem.sv
module mseq_bufmem
   import mseq_pkg::*;
#(
   parameter int unsigned ENTRIES = 128,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned IDX_W   = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              host_we,
   input  logic              host_wsel,
   input  logic [IDX_W-1:0]  host_widx,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [IDX_W-1:0]  host_ridx,
   input  logic              host_take,
   output logic [DATA_W-1:0] host_rx,
   output logic [DATA_W-1:0] host_stat,
   input  logic [IDX_W-1:0]  eng_idx,
   output logic [DATA_W-1:0] eng_tx,
   output logic [DATA_W-1:0] eng_ctrl,
   input  logic              wb_en,
   input  logic [DATA_W-1:0] wb_rx
);
   logic [DATA_W-1:0] tx_q   [ENTRIES];
   logic [DATA_W-1:0] ctl_q  [ENTRIES];
   logic [DATA_W-1:0] rx_q   [ENTRIES];
   logic [DATA_W-1:0] stat_q [ENTRIES];
   logic [DATA_W-1:0] wb_stat;

   always_comb begin
      wb_stat                = '0;
      wb_stat[STAT_DONE_BIT] = 1'b1;
      wb_stat[STAT_UNRD_BIT] = 1'b1;
      wb_stat[STAT_OVR_BIT]  = stat_q[eng_idx][STAT_UNRD_BIT];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < ENTRIES; i++) begin
            tx_q[i]   <= '0;
            ctl_q[i]  <= '0;
            rx_q[i]   <= '0;
            stat_q[i] <= '0;
         end
      end else begin
         if (host_we) begin
            if (host_wsel) ctl_q[host_widx] <= host_wdata;
            else           tx_q[host_widx]  <= host_wdata;
         end
         if (host_take)
            stat_q[host_ridx][STAT_UNRD_BIT] <= 1'b0;
         if (wb_en) begin
            rx_q[eng_idx]   <= wb_rx;
            stat_q[eng_idx] <= wb_stat;
         end
      end
   end

   assign eng_tx    = tx_q[eng_idx];
   assign eng_ctrl  = ctl_q[eng_idx];
   assign host_rx   = rx_q[host_ridx];
   assign host_stat = stat_q[host_ridx];
endmodule

// File: rtl/mseq_top.sv
module mseq_top
   import mseq_pkg::*;
#(
   parameter  int unsigned ENTRIES    = 128,
   parameter  int unsigned DATA_W     = 16,
   parameter  int unsigned NUM_GROUPS = 4,
   parameter  int unsigned NUM_SRC    = 15,
   localparam int unsigned IDX_W      = $clog2(ENTRIES),
   localparam int unsigned SEL_W      = $clog2(NUM_SRC + 1)
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        host_we,
   input  logic                        host_wsel,
   input  logic [IDX_W-1:0]            host_widx,
   input  logic [DATA_W-1:0]           host_wdata,
   input  logic [IDX_W-1:0]            host_ridx,
   input  logic                        host_take,
   output logic [DATA_W-1:0]           host_rx,
   output logic [DATA_W-1:0]           host_stat,
   input  logic [NUM_GROUPS*IDX_W-1:0] cfg_end,
   input  logic [NUM_GROUPS*SEL_W-1:0] cfg_sel,
   input  logic [NUM_GROUPS-1:0]       cfg_mode,
   input  logic [NUM_SRC-1:0]          trig_in,
   output logic                        xfer_req,
   output logic [DATA_W-1:0]           xfer_tx,
   output logic [DATA_W-1:0]           xfer_ctrl,
   input  logic                        xfer_done,
   input  logic [DATA_W-1:0]           xfer_rx,
   output logic [NUM_GROUPS-1:0]       grp_done
);
   localparam int unsigned GRP_W = $clog2(NUM_GROUPS);

   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_chk_entries
      $error("ENTRIES must be a power of two of at least 2");
   end
   if (NUM_GROUPS < 2 || NUM_GROUPS > ENTRIES) begin : g_chk_groups
      $error("NUM_GROUPS must lie in 2..ENTRIES");
   end
   if (NUM_SRC < 1 || NUM_SRC > 15) begin : g_chk_src
      $error("NUM_SRC must lie in 1..15");
   end
   if (DATA_W < 3) begin : g_chk_data
      $error("DATA_W must hold the status bits");
   end

   logic [NUM_GROUPS-1:0]            evt, pend, clr;
   logic [NUM_GROUPS-1:0][IDX_W-1:0] g_start, g_end;
   logic [NUM_GROUPS-1:0]            g_valid;
   seq_state_t                       state;
   logic [IDX_W-1:0]                 idx, cur_end;
   logic [GRP_W-1:0]                 cur, pick;
   logic                             found, wb_en;

   mseq_trig #(.NUM_GROUPS(NUM_GROUPS), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_trig (
      .clk(clk), .rst(rst), .trig_in(trig_in), .cfg_sel(cfg_sel),
      .cfg_mode(cfg_mode), .evt(evt)
   );

   mseq_map #(.NUM_GROUPS(NUM_GROUPS), .IDX_W(IDX_W)) u_map (
      .cfg_end(cfg_end), .g_start(g_start), .g_end(g_end), .g_valid(g_valid)
   );

   mseq_bufmem #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_mem (
      .clk(clk), .rst(rst),
      .host_we(host_we), .host_wsel(host_wsel), .host_widx(host_widx),
      .host_wdata(host_wdata), .host_ridx(host_ridx), .host_take(host_take),
      .host_rx(host_rx), .host_stat(host_stat),
      .eng_idx(idx), .eng_tx(xfer_tx), .eng_ctrl(xfer_ctrl),
      .wb_en(wb_en), .wb_rx(xfer_rx)
   );

   // lowest pending group wins
   always_comb begin
      found = 1'b0;
      pick  = '0;
      for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
         if (pend[g]) begin
            found = 1'b1;
            pick  = GRP_W'(g);
         end
      end
   end

   assign clr      = (state == SEQ_IDLE && found) ? (NUM_GROUPS'(1) << pick) : '0;
   assign xfer_req = (state == SEQ_RUN);
   assign wb_en    = xfer_req & xfer_done;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend     <= '0;
         state    <= SEQ_IDLE;
         idx      <= '0;
         cur      <= '0;
         cur_end  <= '0;
         grp_done <= '0;
      end else begin
         // a new event overrides the clear so level mode re-arms itself
         pend     <= (pend & ~clr) | (evt & g_valid);
         grp_done <= '0;
         case (state)
            SEQ_IDLE: begin
               if (found) begin
                  cur     <= pick;
                  idx     <= g_start[pick];
                  cur_end <= g_end[pick];
                  state   <= SEQ_RUN;
               end
            end
            SEQ_RUN: begin
               if (xfer_done) begin
                  if (idx == cur_end) begin
                     state         <= SEQ_IDLE;
                     grp_done[cur] <= 1'b1;
                  end else begin
                     idx <= idx + IDX_W'(1);
                  end
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk #(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned NUM_GROUPS = 4
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  xfer_req,
   input logic                  xfer_done,
   input logic [DATA_W-1:0]     xfer_tx,
   input logic [DATA_W-1:0]     xfer_ctrl,
   input logic [NUM_GROUPS-1:0] grp_done
);
   assert_req_held_R2: assert property (@(posedge clk) disable iff (rst)
      (xfer_req && !xfer_done) |=> xfer_req)
      else $error("request dropped before done");

   assert_words_stable_R2: assert property (@(posedge clk) disable iff (rst)
      (xfer_req && !xfer_done) |=> ($stable(xfer_tx) && $stable(xfer_ctrl)))
      else $error("request words changed while waiting");

   assert_single_done_R9: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grp_done))
      else $error("more than one completion pulse");

   assert_done_after_wb_R9: assert property (@(posedge clk) disable iff (rst)
      (grp_done != '0) |-> $past(xfer_req && xfer_done))
      else $error("completion without a write-back");

   assert_pulse_width_R9: assert property (@(posedge clk) disable iff (rst)
      (grp_done != '0) |=> (grp_done == '0))
      else $error("completion pulse longer than one cycle");

   assert_idle_after_done_R6: assert property (@(posedge clk) disable iff (rst)
      (grp_done != '0) |-> !xfer_req)
      else $error("request active in the completion cycle");
endmodule

bind mseq_top mseq_chk #(.DATA_W(DATA_W), .NUM_GROUPS(NUM_GROUPS)) u_mseq_chk (
   .clk(clk), .rst(rst), .xfer_req(xfer_req), .xfer_done(xfer_done),
   .xfer_tx(xfer_tx), .xfer_ctrl(xfer_ctrl), .grp_done(grp_done)
);

// File: tb/test_mseq_top.sv
module test_mseq_top;
   localparam int NG = 4;
   localparam int NS = 15;
   localparam int IW = 7;
   localparam int SW = 4;
   localparam int DW = 16;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic           rst;
   logic           host_we, host_wsel, host_take;
   logic [IW-1:0]  host_widx, host_ridx;
   logic [DW-1:0]  host_wdata, host_rx, host_stat;
   logic [NG*IW-1:0] cfg_end;
   logic [NG*SW-1:0] cfg_sel;
   logic [NG-1:0]  cfg_mode, grp_done;
   logic [NS-1:0]  trig_in;
   logic           xfer_req, xfer_done;
   logic [DW-1:0]  xfer_tx, xfer_ctrl, xfer_rx;

   mseq_top #(.ENTRIES(128), .DATA_W(DW), .NUM_GROUPS(NG), .NUM_SRC(NS)) i_mseq_top (
      .clk(clk), .rst(rst),
      .host_we(host_we), .host_wsel(host_wsel), .host_widx(host_widx),
      .host_wdata(host_wdata), .host_ridx(host_ridx), .host_take(host_take),
      .host_rx(host_rx), .host_stat(host_stat),
      .cfg_end(cfg_end), .cfg_sel(cfg_sel), .cfg_mode(cfg_mode), .trig_in(trig_in),
      .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_ctrl(xfer_ctrl),
      .xfer_done(xfer_done), .xfer_rx(xfer_rx), .grp_done(grp_done)
   );

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  sb_off = 1'b0;
   bit  ended = 1'b0;
   int  exp_q[$];
   int  req_cnt = 0;
   int  done_cnt[NG] = '{default: 0};

   function automatic logic [DW-1:0] etx(input int i);
      return 16'h1000 + 16'(i) * 16'h0111;
   endfunction
   function automatic logic [DW-1:0] ectl(input int i);
      return 16'hC000 | 16'(i);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // engine model and scoreboard monitor
   initial begin
      int e;
      xfer_done = 1'b0;
      xfer_rx   = '0;
      forever begin
         @(negedge clk);
         xfer_done = 1'b0;
         if (xfer_req && !rst) begin
            req_cnt++;
            if (!sb_off) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R2 unexpected request", 32'(xfer_tx), 0);
               end else begin
                  e = exp_q.pop_front();
                  chk(xfer_tx == etx(e), "R2 order / R11 tx word", 32'(xfer_tx), 32'(etx(e)));
                  chk(xfer_ctrl == ectl(e), "R11 ctrl word", 32'(xfer_ctrl), 32'(ectl(e)));
               end
            end
            @(negedge clk);
            xfer_rx   = xfer_tx ^ 16'h5A5A;
            xfer_done = 1'b1;
         end
      end
   end

   always @(negedge clk) begin
      for (int g = 0; g < NG; g++)
         if (grp_done[g]) done_cnt[g]++;
   end

   initial begin
      repeat (100000) @(negedge clk);
      chk(1'b0, "watchdog expired", 0, 0);
      finish_run();
   end

   task automatic hwrite(input bit sel, input int idx, input logic [DW-1:0] d);
      @(negedge clk);
      host_we = 1'b1; host_wsel = sel; host_widx = IW'(idx); host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic take(input int idx);
      @(negedge clk);
      host_ridx = IW'(idx); host_take = 1'b1;
      @(negedge clk);
      host_take = 1'b0;
   endtask

   task automatic pulse(input int src);
      @(negedge clk);
      trig_in[src] = 1'b1;
      repeat (3) @(negedge clk);
      trig_in[src] = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic quiet();
      int q = 0;
      while (q < 20) begin
         @(negedge clk);
         if (xfer_req) q = 0; else q++;
      end
   endtask

   task automatic expect_group(input int first, input int last);
      for (int i = first; i <= last; i++) exp_q.push_back(i);
   endtask

   task automatic check_entries(input int first, input int last, input logic [DW-1:0] st, input string tag);
      for (int i = first; i <= last; i++) begin
         host_ridx = IW'(i);
         #1;
         chk(host_stat == st, tag, 32'(host_stat), 32'(st));
         chk(host_rx == (etx(i) ^ 16'h5A5A), "R3 receive word", 32'(host_rx), 32'(etx(i) ^ 16'h5A5A));
      end
   endtask

   initial begin
      int base_req;
      int base_done;
      rst = 1'b1;
      host_we = 1'b0; host_wsel = 1'b0; host_widx = '0; host_wdata = '0;
      host_ridx = '0; host_take = 1'b0;
      trig_in = '0;
      // g0: 0..3, g1: 4..5, g2: 6..8, g3: end 2 < start 9 (empty)
      cfg_end  = {7'd2, 7'd8, 7'd5, 7'd3};
      cfg_sel  = {4'd4, 4'd3, 4'd2, 4'd1};
      cfg_mode = '0;
      repeat (4) @(negedge clk);
      rst = 1'b0;

      // R1 reset state
      host_ridx = 7'd0;
      #1;
      chk(xfer_req == 1'b0, "R1 request idle", 32'(xfer_req), 0);
      chk(grp_done == '0, "R1 no completion", 32'(grp_done), 0);
      chk(host_stat == '0, "R1 status cleared", 32'(host_stat), 0);

      for (int i = 0; i < 10; i++) begin
         hwrite(1'b0, i, etx(i));
         hwrite(1'b1, i, ectl(i));
      end

      // R2 R3 R5: edge-triggered walk of group 0
      expect_group(0, 3);
      pulse(0);
      quiet();
      chk(done_cnt[0] == 1, "R9 one pulse per run", 32'(done_cnt[0]), 1);
      check_entries(0, 3, 16'h0005, "R3 status after first run");

      // R4 overrun when not read
      expect_group(0, 3);
      pulse(0);
      quiet();
      check_entries(0, 3, 16'h0007, "R4 overrun set");
      for (int i = 0; i < 4; i++) take(i);
      host_ridx = 7'd2;
      #1;
      chk(host_stat == 16'h0003, "R4 take clears unread", 32'(host_stat), 32'h3);
      expect_group(0, 3);
      pulse(0);
      quiet();
      check_entries(0, 3, 16'h0005, "R4 no overrun after take");

      // R6 priority: g1 and g2 fire together
      expect_group(4, 5);
      expect_group(6, 8);
      @(negedge clk);
      trig_in[1] = 1'b1; trig_in[2] = 1'b1;
      repeat (3) @(negedge clk);
      trig_in[1] = 1'b0; trig_in[2] = 1'b0;
      quiet();
      chk(done_cnt[1] == 1 && done_cnt[2] == 1, "R6 both groups served once",
          32'(done_cnt[1] + done_cnt[2]), 2);

      // R7 trigger during a run is held
      expect_group(6, 8);
      expect_group(0, 3);
      pulse(2);
      while (!xfer_req) @(negedge clk);
      pulse(0);
      quiet();
      chk(done_cnt[0] == 4, "R7 held trigger served", 32'(done_cnt[0]), 4);
      chk(exp_q.size() == 0, "R7 scoreboard drained", 32'(exp_q.size()), 0);

      // R5 select value 0 never fires
      base_req = req_cnt;
      cfg_sel[3:0] = 4'd0;
      pulse(0);
      quiet();
      chk(req_cnt == base_req, "R5 select zero ignored", 32'(req_cnt), 32'(base_req));
      cfg_sel[3:0] = 4'd1;

      // R10 empty group ignored
      pulse(3);
      quiet();
      chk(req_cnt == base_req && done_cnt[3] == 0, "R10 empty group never runs",
          32'(req_cnt), 32'(base_req));

      // R8 level-low restart
      expect_group(4, 5);
      @(negedge clk);
      trig_in[1] = 1'b1;
      quiet();
      cfg_mode[1] = 1'b1;
      sb_off = 1'b1;
      base_done = done_cnt[1];
      @(negedge clk);
      trig_in[1] = 1'b0;
      repeat (60) @(negedge clk);
      trig_in[1] = 1'b1;
      repeat (40) @(negedge clk);
      chk(done_cnt[1] - base_done >= 3, "R8 repeated runs while low",
          32'(done_cnt[1] - base_done), 3);
      base_done = done_cnt[1];
      base_req  = req_cnt;
      repeat (60) @(negedge clk);
      chk(done_cnt[1] == base_done && req_cnt == base_req, "R8 stops after release",
          32'(req_cnt), 32'(base_req));
      chk(exp_q.size() == 0, "R2 scoreboard empty", 32'(exp_q.size()), 0);

      finish_run();
   end
endmodule